// File: doc/BRIEF.md
# Field Memory Write Port

This block drives the write side of a field-delay memory: a large dual-port array that a video pipeline writes one field into and reads back a field later. It runs entirely on the write clock. It keeps a write address pointer, turns the incoming 10-bit words into a write strobe, an address and a data word for the array, and enforces the timing rules that bound a write run.

Two controls shape a run. The write enable decides whether the pointer moves at all. The input enable only decides whether the addressed location is overwritten, so regions of a picture can be skipped while the pointer keeps stepping. Both controls, and the data word that goes with them, pass through a fixed four-stage pipeline before they reach the array. A write-reset input returns the pointer to zero and starts a lockout window during which the write enable is ignored. If a new write reset arrives before the current run has stored enough words, a sticky error flag rises.

Top module: `fieldmem_wport`

## Requirements
- R1: A write reset sampled high at a rising edge sets `wr_addr` to 0 and discards every enable and data sample still inside the pipeline, so `wr_en` is 0 after that edge.
- R2: A cycle whose write enable is sampled low leaves the pointer unchanged and produces no write when it leaves the pipeline.
- R3: A cycle sampled with write enable high and input enable low advances the pointer by one but keeps `wr_en` low for that slot.
- R4: A sample taken at edge n appears on `wr_en`, `wr_addr` and `wr_data` after edge n+3 and is committed to the array at edge n+4; the pointer moves at that same edge n+4.
- R5: The first word stored after a write reset goes to address 0.
- R6: For the LOCKOUT edges that follow a write reset, the write enable is treated as low.
- R7: `run_err` rises at a write reset when fewer than MIN_RUN words have been stored since the previous write reset; it stays high until `rst_n` is asserted. The first write reset after `rst_n` never raises it.
- R8: After address DEPTH-1 the pointer wraps to 0 when no write reset intervenes.
- R9: While and after `rst_n` is low, `wr_en`, `wr_addr` and `run_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_rst | input | 1 | Write reset: clears the pointer at the next rising edge |
| we_in | input | 1 | Write enable: pointer advances when high |
| ie_in | input | 1 | Input enable: masks storage when low |
| din | input | DW | Input word sampled with the enables |
| wr_en | output | 1 | Write strobe to the array |
| wr_addr | output | $clog2(DEPTH) | Write address to the array |
| wr_data | output | DW | Write data to the array |
| run_err | output | 1 | Sticky flag for a write run that was too short |

## Verification
Every result of a sample taken at edge n is due on the array side after edge n+3, the pointer step after edge n+4, and the lockout and error flag update at the reset edge itself. The bench drives inputs and samples outputs on falling edges, keeping a four-deep record of what it drove together with an expected pointer, lockout count and run count derived from the requirements, so each output is compared in exactly the half cycle in which it is due. Directed scenarios then check the specific edges named by the requirements, such as the first write to address 0 after the lockout and the pipeline flush at a mid-stream reset.

// File: rtl/fieldmem_wport.sv
module fieldmem_wport #(
  parameter int DEPTH   = 64,
  parameter int DW      = 10,
  parameter int LAT     = 4,
  parameter int LOCKOUT = 8,
  parameter int MIN_RUN = 231
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_rst,
  input  logic                     we_in,
  input  logic                     ie_in,
  input  logic [DW-1:0]            din,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [DW-1:0]            wr_data,
  output logic                     run_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(LOCKOUT + 1);
  localparam int RW = $clog2(MIN_RUN + 1);

  logic [LAT-1:0] we_p, ie_p;
  logic [DW-1:0]  d_p [LAT];
  logic [AW-1:0]  ptr;
  logic [LW-1:0]  lock;
  logic [RW-1:0]  run;
  logic           armed, err;

  wire we_ok = we_in & (lock == '0);
  wire adv   = we_p[LAT-1];

  assign wr_en   = we_p[LAT-1] & ie_p[LAT-1];
  assign wr_addr = ptr;
  assign wr_data = d_p[LAT-1];
  assign run_err = err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_p <= '0;
      ie_p <= '0;
      for (int i = 0; i < LAT; i++) d_p[i] <= '0;
    end else if (wr_rst) begin
      we_p <= '0;
      ie_p <= '0;
    end else begin
      we_p <= {we_p[LAT-2:0], we_ok};
      ie_p <= {ie_p[LAT-2:0], ie_in};
      d_p[0] <= din;
      for (int i = 1; i < LAT; i++) d_p[i] <= d_p[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      lock <= '0;
    end else if (wr_rst) begin
      ptr  <= '0;
      lock <= LW'(LOCKOUT);
    end else begin
      if (adv) ptr <= (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      if (lock != '0) lock <= lock - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      armed <= 1'b0;
      err   <= 1'b0;
    end else if (wr_rst) begin
      if (armed && run < RW'(MIN_RUN)) err <= 1'b1;
      armed <= 1'b1;
      run   <= '0;
    end else if (wr_en && run != RW'(MIN_RUN)) begin
      run <= run + 1'b1;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> (wr_addr == '0) && !wr_en);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && !adv) |=> $stable(wr_addr));

  a_r3_masked_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && adv && !wr_en && wr_addr != AW'(DEPTH - 1)) |=> wr_addr == $past(wr_addr) + 1'b1);

  a_r6_lockout_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (lock != '0 && !wr_rst) |=> !we_p[0]);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run_err |=> run_err);

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && adv && wr_addr == AW'(DEPTH - 1)) |=> wr_addr == '0);
endmodule

// File: tb/fieldmem_wport_test.sv
`timescale 1ns/1ps
module fieldmem_wport_test;
  localparam int DEPTH = 16;
  localparam int LOCK  = 3;
  localparam int MINR  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_i = 1'b0, we_i = 1'b0, ie_i = 1'b0;
  logic [9:0] din_i = '0;
  logic wr_en, run_err;
  logic [3:0] wr_addr;
  logic [9:0] wr_data;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fieldmem_wport #(.DEPTH(DEPTH), .DW(10), .LAT(4), .LOCKOUT(LOCK), .MIN_RUN(MINR)) uut (
    .clk(clk), .rst_n(rst_n), .wr_rst(rst_i), .we_in(we_i), .ie_in(ie_i), .din(din_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .run_err(run_err));

  bit hw[4], hi[4];
  logic [9:0] hd[4];
  int ea = 0, lk = 0, run = 0;
  bit armed = 0, eerr = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit w, input bit i, input logic [9:0] d, input string tag);
    rst_i = r; we_i = w; ie_i = i; din_i = d;
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      if (armed && run < MINR) eerr = 1;
      armed = 1; run = 0; ea = 0; lk = LOCK;
      for (int k = 0; k < 4; k++) begin hw[k] = 0; hi[k] = 0; end
    end else begin
      if (hw[3]) ea = (ea == DEPTH - 1) ? 0 : ea + 1;
      if (hw[3] && hi[3] && run < MINR) run++;
      for (int k = 3; k > 0; k--) begin hw[k] = hw[k-1]; hi[k] = hi[k-1]; hd[k] = hd[k-1]; end
      hw[0] = w && (lk == 0); hi[0] = i; hd[0] = d;
      if (lk > 0) lk--;
    end
    chk(tag, wr_en, hw[3] & hi[3]);
    chk(tag, wr_addr, ea);
    if (hw[3] & hi[3]) chk(tag, wr_data, hd[3]);
    chk("R7", run_err, eerr);
  endtask

  task automatic t_reset_state;
    chk("R9", wr_en, 0);
    chk("R9", wr_addr, 0);
    chk("R9", run_err, 0);
  endtask

  task automatic t_first_run;
    step(1, 0, 0, 10'd0, "R1");
    chk("R1", wr_addr, 0);
    for (int k = 0; k < LOCK + 8; k++) begin
      step(0, 1, 1, 10'(k * 37 + 5), "R4");
      if (k < LOCK + 3) chk("R6", wr_en, 0);
      if (k == LOCK + 3) begin
        chk("R5", wr_en, 1);
        chk("R5", wr_addr, 0);
        chk("R5", wr_data, (LOCK * 37 + 5) % 1024);
      end
    end
  endtask

  task automatic t_gaps;
    bit wp[8] = '{1, 0, 0, 1, 1, 1, 0, 1};
    bit ip[8] = '{1, 1, 1, 0, 0, 1, 1, 0};
    for (int k = 0; k < 8; k++) step(0, wp[k], ip[k], 10'(k * 11 + 300), k < 3 ? "R2" : "R3");
    for (int k = 0; k < 4; k++) step(0, 0, 1, 10'h3ff, "R2");
  endtask

  task automatic t_wrap;
    for (int k = 0; k < 20; k++) step(0, 1, 1, 10'(k * 5 + 700), "R8");
  endtask

  task automatic t_reset_mid;
    step(0, 1, 1, 10'd9, "R4");
    step(1, 1, 1, 10'd10, "R1");
    chk("R1", wr_en, 0);
    chk("R1", wr_addr, 0);
    chk("R7", run_err, 0);
    for (int k = 0; k < LOCK + 5; k++) step(0, 1, 1, 10'(k + 40), "R6");
  endtask

  task automatic t_short_run;
    step(1, 0, 0, 10'd0, "R1");
    for (int k = 0; k < LOCK; k++) step(0, 0, 0, 10'd0, "R6");
    step(0, 1, 1, 10'd77, "R4");
    step(0, 1, 1, 10'd78, "R4");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 10'd0, "R2");
    step(1, 0, 0, 10'd0, "R7");
    chk("R7", run_err, 1);
    for (int k = 0; k < 12; k++) step(0, 1, 1, 10'(k), "R7");
    chk("R7", run_err, 1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state;
    t_first_run;
    t_gaps;
    t_wrap;
    t_reset_mid;
    t_short_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule